// File: doc/BRIEF.md
# Multi-Tone Additive Sine Synthesizer

This block mixes several independent sine tones into one signed 16-bit sample stream. Each tone keeps its own 32-bit phase, which advances by that tone's increment once per sample. The tone's amplitude is set by its own signed gain. One quarter-wave amplitude table serves every tone. The table contents are computed when the design is elaborated. The tones are handled one after another, one tone per clock, so a single lookup and a single multiplier do all the work. At a 40 kHz sample rate a 50 MHz clock leaves far more cycles per sample than eight tones need.

Software or a sequencer loads increments and gains through a small write port into a staging set. A pulse on `sample_tick` copies the staging set into the working set and starts a pass over all tones. When the pass ends, the rounded and saturated mix appears on `mix_out` with a one-cycle `out_valid` strobe. The increment sets the tone frequency: an increment of about 2147484 gives 20 Hz at 40 kHz.

Top module: `tone_mixer`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, all phases, staged and working increments, and staged and working gains become 0, `mix_out` becomes 0 and `out_valid` becomes 0. The first sample after reset with no writes is therefore 0.
- R2: Each tone has a 32-bit phase. A sample is computed from the phases as they stand. Each phase then advances by its working increment, modulo 2^32.
- R3: The sine of a phase p uses a 257-entry table whose entry i holds round(32767·sin(i·π/512)). The index is p[29:22]. When p[30]=1 the index becomes 256 − p[29:22]. When p[31]=1 the looked-up value is negated.
- R4: The mix is the sum over all tones of sine × gain, with the gain a signed 16-bit value. The sum is rounded by adding 2^14 and shifting right arithmetically by 15.
- R5: A write with `wr_en`=1 targets tone `wr_tone`. With `wr_sel`=0 it stages the full 32-bit `wr_data` as the increment. With `wr_sel`=1 it stages `wr_data[15:0]` as the gain. Staged values take effect at the next sample tick. A write on the same clock as a tick takes effect one tick later.
- R6: `out_valid` pulses high for exactly one cycle, 8 clocks after the edge that samples `sample_tick`. `mix_out` holds its value between pulses.
- R7: A `sample_tick` that arrives while a pass is in progress is ignored. It produces no extra output pulse and leaves the working parameters unchanged.
- R8: A tone whose increment is 0 keeps its phase from sample to sample. A tone whose gain is 0 contributes nothing to the mix.
- R9: A rounded mix above 32767 gives 32767, and a rounded mix below −32768 gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Parameter write strobe |
| wr_sel | input | 1 | 0 = increment, 1 = gain |
| wr_tone | input | 3 | Tone number being written |
| wr_data | input | 32 | Increment, or gain in bits 15:0 |
| sample_tick | input | 1 | Starts one output sample |
| mix_out | output | 16 | Mixed signed sample |
| out_valid | output | 1 | One-cycle strobe for a new `mix_out` |

## Verification
Two events can fall on the same clock edge. The first is a parameter write coinciding with a sample tick. The bench drives the write and the tick in the same cycle and expects the next sample to use the old staged value and the one after it the new value. The second is a tick arriving while a pass is still running. The bench raises it three cycles into a pass and expects exactly one strobe, with every later sample still matching its phase model. All samples are compared with a bench model built from real-valued sine, allowing 2 LSB for table rounding.

// File: rtl/tone_mixer.sv
module tone_mixer #(
  parameter int NT = 8,
  parameter int PW = 32,
  parameter int GW = 16,
  parameter int OW = 16,
  parameter int QB = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [$clog2(NT)-1:0]  wr_tone,
  input  logic [PW-1:0]          wr_data,
  input  logic                   sample_tick,
  output logic [OW-1:0]          mix_out,
  output logic                   out_valid
);
  localparam int CW = $clog2(NT);
  localparam int QN = 1 << QB;
  localparam int PRW = OW + GW;
  localparam int AW = PRW + CW;
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (OW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - 1;
  localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (GW-2));

  function automatic logic [OW*(QN+1)-1:0] build_qtab();
    logic [OW*(QN+1)-1:0] t;
    longint x, term, s;
    t = '0;
    for (int i = 0; i <= QN; i++) begin
      x = (longint'(i) * 64'sd1686629713) / QN;
      term = x;
      s = x;
      for (int k = 1; k <= 7; k++) begin
        term = (term * x) >>> 30;
        term = (term * x) >>> 30;
        term = -term / longint'(2*k*(2*k+1));
        s = s + term;
      end
      t[OW*i +: OW] = OW'((s * ((64'sd1 <<< (OW-1)) - 1) + (64'sd1 <<< 29)) >>> 30);
    end
    return t;
  endfunction

  localparam logic [OW*(QN+1)-1:0] QTAB = build_qtab();

  logic [PW-1:0] ph      [NT];
  logic [PW-1:0] inc_stg [NT];
  logic [PW-1:0] inc_act [NT];
  logic [GW-1:0] gn_stg  [NT];
  logic [GW-1:0] gn_act  [NT];
  logic          busy;
  logic [CW-1:0] cnt;
  logic signed [AW-1:0] acc;

  logic unused_hi;
  assign unused_hi = ^wr_data[PW-1:GW];

  logic [PW-1:0] cur_ph;
  logic [QB-1:0] qidx;
  logic [QB:0]   addr;
  logic signed [OW-1:0]  mag, sval;
  logic signed [GW-1:0]  gval;
  logic signed [PRW-1:0] prod;
  logic signed [AW-1:0]  acc_nx, rnd, shr;

  assign cur_ph = ph[cnt];
  assign qidx   = cur_ph[PW-3 -: QB];
  assign addr   = cur_ph[PW-2] ? (QB+1)'(QN) - {1'b0, qidx} : {1'b0, qidx};
  assign mag    = QTAB[OW*addr +: OW];
  assign sval   = cur_ph[PW-1] ? -mag : mag;
  assign gval   = gn_act[cnt];
  assign prod   = sval * gval;
  assign acc_nx = acc + {{(AW-PRW){prod[PRW-1]}}, prod};
  assign rnd    = acc_nx + HALF;
  assign shr    = rnd >>> (GW-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++) begin
        ph[t] <= '0; inc_stg[t] <= '0; inc_act[t] <= '0;
        gn_stg[t] <= '0; gn_act[t] <= '0;
      end
      busy <= 1'b0; cnt <= '0; acc <= '0;
      mix_out <= '0; out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (wr_en) begin
        if (wr_sel) gn_stg[wr_tone] <= wr_data[GW-1:0];
        else        inc_stg[wr_tone] <= wr_data;
      end
      if (!busy) begin
        if (sample_tick) begin
          for (int t = 0; t < NT; t++) begin
            inc_act[t] <= inc_stg[t];
            gn_act[t]  <= gn_stg[t];
          end
          busy <= 1'b1; cnt <= '0; acc <= '0;
        end
      end else begin
        ph[cnt] <= cur_ph + inc_act[cnt];
        acc <= acc_nx;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NT-1)) begin
          busy <= 1'b0;
          out_valid <= 1'b1;
          mix_out <= (shr > MAXV) ? OW'(MAXV) : (shr < MINV) ? OW'(MINV) : shr[OW-1:0];
        end
      end
    end
  end

  logic [NT*PW-1:0] ph_flat, inc_flat;
  for (genvar g = 0; g < NT; g++) begin : g_flat
    assign ph_flat[g*PW +: PW]  = ph[g];
    assign inc_flat[g*PW +: PW] = inc_act[g];
  end

  AST_PHASE_IDLE:  assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(ph_flat));              // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);               // R6
  AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(mix_out));        // R6
  AST_TICK_IGNORE: assert property (@(posedge clk) disable iff (rst) (busy && sample_tick) |=> $stable(inc_flat)); // R7
  AST_NO_PASS_START: assert property (@(posedge clk) disable iff (rst) out_valid |-> !busy);                  // R7
endmodule

// File: tb/tone_mixer_bench.sv
module tone_mixer_bench;
  localparam int NT = 8;
  logic clk = 0, rst = 1, wr_en = 0, wr_sel = 0, sample_tick = 0;
  logic [2:0] wr_tone = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] mix_out;
  logic out_valid;

  tone_mixer u_tone_mixer (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_tone(wr_tone), .wr_data(wr_data), .sample_tick(sample_tick),
    .mix_out(mix_out), .out_valid(out_valid));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit [31:0] m_ph [NT], s_inc [NT], a_inc [NT];
  bit [15:0] s_gn [NT], a_gn [NT];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected fewer", cyc);
      summary();
    end
  end

  function automatic int ref_sin(bit [31:0] p);
    int idx;
    real v;
    int r;
    idx = p[29:22];
    if (p[30]) idx = 256 - idx;
    v = 32767.0 * $sin(idx * 3.14159265358979 / 512.0);
    r = $rtoi($floor(v + 0.5));
    return p[31] ? -r : r;
  endfunction

  function automatic int ref_mix();
    longint acc = 0;
    longint r;
    for (int t = 0; t < NT; t++)
      acc += longint'(ref_sin(m_ph[t])) * longint'($signed(a_gn[t]));
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(string req, int act, int exp, int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stage(bit sel, int tone, bit [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_tone = 3'(tone); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (sel) s_gn[tone] = d[15:0]; else s_inc[tone] = d;
  endtask

  // one sample; optional coincident write and optional tick during the pass
  task automatic sample(output int got, input bit w, input bit sel, input int tone,
                        input bit [31:0] d, input bit busy_tick);
    int n, exp, extra;
    @(negedge clk);
    sample_tick = 1;
    if (w) begin wr_en = 1; wr_sel = sel; wr_tone = 3'(tone); wr_data = d; end
    for (int t = 0; t < NT; t++) begin a_inc[t] = s_inc[t]; a_gn[t] = s_gn[t]; end
    if (w) begin if (sel) s_gn[tone] = d[15:0]; else s_inc[tone] = d; end
    @(negedge clk);
    sample_tick = 0; wr_en = 0;
    n = 1;
    while (!out_valid && n < 40) begin
      @(negedge clk); n++;
      if (busy_tick) sample_tick = (n == 3);
    end
    sample_tick = 0;
    check("R6 latency", n, NT + 1, 0);
    exp = ref_mix();
    got = $signed(mix_out);
    check("R2/R3/R4 mix", got, exp, 2);
    for (int t = 0; t < NT; t++) m_ph[t] = m_ph[t] + a_inc[t];
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (out_valid) extra++;
      if (k == 5 && busy_tick) check("R6 hold", $signed(mix_out), got, 0);
    end
    if (busy_tick) check("R7 extra pulses", extra, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int t = 0; t < NT; t++) begin m_ph[t] = 0; s_inc[t] = 0; a_inc[t] = 0; s_gn[t] = 0; a_gn[t] = 0; end
  endtask

  initial begin
    int got, prev;
    bit [31:0] r;
    void'($urandom(1234));
    do_reset();
    check("R1 out", mix_out, 0, 0);
    check("R1 valid", out_valid, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R1 first sample", got, 0, 0);

    // quarter-turn steps on tone 0
    stage(0, 0, 32'h4000_0000);
    stage(1, 0, 32'h0000_7FFF);
    for (int k = 0; k < 4; k++) sample(got, 0, 0, 0, 0, 0);

    // write coincident with tick (R5): old gain for this sample, new for the next
    sample(got, 1, 1, 0, 32'h0000_C000, 0);
    check("R5 coincident old gain", a_gn[0], 16'h7FFF, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R5 coincident new gain", a_gn[0], 16'hC000, 0);

    // R8: zero increment holds phase, output repeats
    stage(0, 0, 32'h1234_5678);
    sample(got, 0, 0, 0, 0, 0);
    stage(0, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    sample(prev, 0, 0, 0, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R8 held phase", got, prev, 0);
    // R8: zero gain silences the tone
    stage(1, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R8 zero gain", got, 0, 0);

    // R7: tick during pass
    stage(0, 3, 32'd2147484);
    stage(1, 3, 32'h0000_6000);
    for (int k = 0; k < 3; k++) sample(got, 0, 0, 0, 0, 1);

    // R9: all tones at full gain, in phase
    do_reset();
    for (int t = 0; t < NT; t++) begin stage(0, t, 32'h4000_0000); stage(1, t, 32'h0000_7FFF); end
    sample(got, 0, 0, 0, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R9 high clip", got, 32767, 0);
    sample(got, 0, 0, 0, 0, 0);
    sample(got, 0, 0, 0, 0, 0);
    check("R9 low clip", got, -32768, 0);

    // constrained random mix
    for (int s = 0; s < 60; s++) begin
      if (s % 6 == 0) begin
        for (int t = 0; t < NT; t++) begin
          r = $urandom;
          stage(0, t, (s % 12 == 0) ? r : (r >> 8));
          r = $urandom;
          stage(1, t, {16'h0, r[15:0] >>> ($urandom % 4)});
        end
      end
      sample(got, (s % 5 == 2), s[0], s % NT, $urandom, (s % 7 == 3));
    end
    summary();
  end
endmodule